// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transmitter

This block turns queued characters into asynchronous serial frames on one output line. A four-bit format code selects one of five frame layouts:

- eight data bits;
- seven data bits;
- eight data bits followed by an odd-parity bit;
- eight data bits followed by an even-parity bit;
- eight data bits followed by an address/data flag bit.

Every frame opens with a low start bit and closes with a high stop bit. Data goes out least significant bit first.

Bit timing comes from an external baud-rate enable pulse. A speed selector sets each bit to 16 pulses or 4 pulses. Characters enter through a valid/ready handshake into a small holding queue. A flush input empties that queue.

The transmit enable gates only the start of new frames. A frame already on the line runs to completion. Characters left in the queue stay there until they are sent or flushed. A pin-drive enable tells the pad logic when to drive the line. It is asserted only while a frame is being sent and transmit is enabled.

Format code and speed are captured when a frame starts. Changing them mid-frame therefore affects only later frames.

Top module: `frame_tx`

## Requirements
- R1: After reset the line is high, busy and drive-enable are low, in_ready is high and the queue is empty.
- R2: Format code 0000 sends a start bit (0), data bits 0 to 7 least significant first, then a stop bit (1): 10 bit times.
- R3: Format code 0001 sends a start bit, data bits 0 to 6, then a stop bit: 9 bit times. Data bit 7 is not sent.
- R4: Format code 0010 sends start, 8 data bits, then a ninth bit chosen so that the count of ones over the data bits and the ninth bit is odd, then stop.
- R5: Format code 0011 sends start, 8 data bits, then a ninth bit chosen so that the count of ones over the data bits and the ninth bit is even, then stop.
- R6: Format code 0100 sends start, 8 data bits, then a ninth bit equal to the in_addr value stored with that character, then stop.
- R7: With fast_sel at 1 each bit lasts 4 baud_tick pulses. With fast_sel at 0 each bit lasts 16. The line changes only in the cycle after a baud_tick pulse.
- R8: drive_en is high exactly while busy and tx_en are both high. It is never high while tx_en is low.
- R9: With tx_en low no new frame starts and queued characters are kept. A frame in progress when tx_en falls still completes. Kept characters are sent once tx_en returns high.
- R10: flush empties the queue in one cycle. A character offered in the same cycle is discarded, and no frame starts in that cycle.
- R11: Format codes above 0100 start no frame. The line stays high and queued characters remain queued until a valid code is applied.
- R12: Format code and fast_sel are captured in the cycle a frame starts. Changes during a frame do not alter that frame.
- R13: The queue holds DEPTH characters in arrival order, and in_ready is low while it is full. A frame starts in the cycle after an idle cycle in which tx_en is high, the queue is non-empty and flush is low. At least one idle cycle separates consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle baud-rate enable pulse |
| fast_sel | input | 1 | 1: 4 pulses per bit, 0: 16 pulses per bit |
| fmt_code | input | 4 | Frame format code |
| tx_en | input | 1 | Allows new frames to start |
| in_data | input | 8 | Character to queue |
| in_addr | input | 1 | Address flag stored with the character |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Queue can accept a character |
| flush | input | 1 | Empty the queue |
| txd | output | 1 | Serial line, idles high |
| drive_en | output | 1 | Pad drive enable during an enabled frame |
| busy | output | 1 | A frame is in progress |

## Verification
A behavioural model inside the bench advances once per rising edge from the inputs held during that cycle. Its view of txd, busy, drive_en and in_ready is compared with the design at the following falling edge.

Timing follows directly from the register layout:
- busy and the start bit appear one cycle after the start condition holds.
- Each bit boundary moves one cycle after the baud pulse that completes the count.
- in_ready reflects a push or flush one cycle later.
- drive_en follows tx_en within the same cycle.

Inputs change one time unit after the rising edge, so every comparison sees settled values. Separate checks confirm the reset values, the full-queue condition, and the absence of frames after a flush and under reserved codes.

// File: rtl/frame_tx_pkg.sv
// Shared types and frame assembly helpers for the serial transmitter.
// Assumes format codes 0000..0100 are the only transmitting formats.
package frame_tx_pkg;

    localparam int FRAME_MAX = 11;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [3:0] {
        FMT_D8   = 4'b0000,
        FMT_D7   = 4'b0001,
        FMT_ODD  = 4'b0010,
        FMT_EVEN = 4'b0011,
        FMT_ADDR = 4'b0100
    } fmt_e;

    typedef struct packed {
        logic       flag;
        logic [7:0] data;
    } char_t;

    // True when a code selects a transmitting format.
    function automatic logic fmt_ok(input logic [3:0] code);
        return code <= FMT_ADDR;
    endfunction

    // Number of bit times (start, payload, stop) for a format.
    function automatic logic [LEN_W-1:0] frame_len(input logic [3:0] code);
        case (code)
            FMT_D8:  return LEN_W'(10);
            FMT_D7:  return LEN_W'(9);
            default: return LEN_W'(11);
        endcase
    endfunction

    // Frame bits, bit 0 sent first; positions past the frame length are 1.
    function automatic logic [FRAME_MAX-1:0] build_frame(input logic [3:0] code,
                                                         input char_t ch);
        case (code)
            FMT_D8:   return {2'b11, ch.data, 1'b0};
            FMT_D7:   return {3'b111, ch.data[6:0], 1'b0};
            FMT_ODD:  return {1'b1, ~(^ch.data), ch.data, 1'b0};
            FMT_EVEN: return {1'b1, ^ch.data, ch.data, 1'b0};
            FMT_ADDR: return {1'b1, ch.flag, ch.data, 1'b0};
            default:  return '1;
        endcase
    endfunction

endpackage

// File: rtl/ftx_hold_buf.sv
// Small first-in first-out holding queue for outgoing characters.
// Assumes push is only offered while not full; flush has priority over push and pop.
module ftx_hold_buf #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_ptr];

    // Write storage on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ftx_engine.sv
// Bit-serial shift engine: loads a prepared frame and steps it out on baud ticks.
// Assumes start is only raised while idle; speed is latched at the start.
module ftx_engine #(
    parameter int FRAME_MAX  = 11,
    parameter int LEN_W      = 4,
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 start,
    input  logic                 fast,
    input  logic [FRAME_MAX-1:0] frame_bits,
    input  logic [LEN_W-1:0]     frame_len,
    output logic                 line,
    output logic                 active
);
    localparam int TMAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int TCW  = $clog2(TMAX);

    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     bits_left;
    logic [TCW-1:0]       tick_cnt;
    logic [TCW-1:0]       tick_last;

    assign line = active ? shreg[0] : 1'b1;

    // Frame load, per-bit tick counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            tick_last <= '0;
        end else if (start) begin
            active    <= 1'b1;
            shreg     <= frame_bits;
            bits_left <= frame_len;
            tick_cnt  <= '0;
            tick_last <= fast ? TCW'(FAST_TICKS - 1) : TCW'(SLOW_TICKS - 1);
        end else if (active && baud_tick) begin
            if (tick_cnt == tick_last) begin
                tick_cnt  <= '0;
                shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == LEN_W'(1)) begin
                    active <= 1'b0;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_tx.sv
// Top of the multi-format serial transmitter: queue, frame builder, shift engine.
// Assumes baud_tick is a single-cycle enable; format and speed sampled per frame.
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       fast_sel,
    input  logic [3:0] fmt_code,
    input  logic       tx_en,
    input  logic [7:0] in_data,
    input  logic       in_addr,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       flush,
    output logic       txd,
    output logic       drive_en,
    output logic       busy
);
    char_t              head;
    logic               q_empty, q_full, start;
    logic [FRAME_MAX-1:0] bits;

    // Start a frame only from idle, enabled, with a valid format and no flush.
    always_comb begin
        start = !busy && tx_en && !q_empty && !flush && fmt_ok(fmt_code);
        bits  = build_frame(fmt_code, head);
    end

    assign in_ready = !q_full;
    assign drive_en = busy && tx_en;

    ftx_hold_buf #(.W($bits(char_t)), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid && !q_full),
        .wr_data ({in_addr, in_data}),
        .pop     (start),
        .flush   (flush),
        .rd_data (head),
        .empty   (q_empty),
        .full    (q_full)
    );

    ftx_engine #(
        .FRAME_MAX (FRAME_MAX),
        .LEN_W     (LEN_W),
        .SLOW_TICKS(SLOW_TICKS),
        .FAST_TICKS(FAST_TICKS)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .start     (start),
        .fast      (fast_sel),
        .frame_bits(bits),
        .frame_len (frame_len(fmt_code)),
        .line      (txd),
        .active    (busy)
    );
endmodule

// File: rtl/frame_tx_checker.sv
// Temporal properties of the transmitter, observed at its ports.
// Assumes it is bound to frame_tx with matching port names.
module frame_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       fast_sel,
    input logic [3:0] fmt_code,
    input logic       tx_en,
    input logic [7:0] in_data,
    input logic       in_addr,
    input logic       in_valid,
    input logic       in_ready,
    input logic       flush,
    input logic       txd,
    input logic       drive_en,
    input logic       busy
);
    logic unused_ok;
    assign unused_ok = ^{fast_sel, in_data, in_addr, in_valid};

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);                                   // R2
    AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));                             // R2
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(txd));                  // R7
    AST_NO_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !drive_en);                                   // R8
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_en) |=> !busy);                            // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> in_ready);                                     // R10
    AST_FLUSH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && flush) |=> !busy);                             // R10
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (fmt_code > 4'b0100)) |=> !busy);              // R11
endmodule

bind frame_tx frame_tx_checker u_chk (.*);

// File: tb/frame_tx_test.sv
`timescale 1ns/100ps
module frame_tx_test;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, baud_tick = 1'b0, fast_sel = 1'b0, tx_en = 1'b0;
    logic       in_valid = 1'b0, in_addr = 1'b0, flush = 1'b0;
    logic [3:0] fmt_code = 4'b0000;
    logic [7:0] in_data = 8'h00;
    wire        txd, drive_en, busy, in_ready;

    frame_tx #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fast_sel(fast_sel),
        .fmt_code(fmt_code), .tx_en(tx_en), .in_data(in_data), .in_addr(in_addr),
        .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
        .txd(txd), .drive_en(drive_en), .busy(busy)
    );

    int    vectors = 0, errors = 0;
    string cur_req = "R1";
    int    tick_div = 1, tick_ph = 0;

    // Baud pulse generator: one pulse every tick_div cycles.
    always @(posedge clk) begin
        #1;
        if (tick_ph + 1 >= tick_div) begin tick_ph = 0; baud_tick = 1'b1; end
        else begin tick_ph++; baud_tick = 1'b0; end
    end

    // Behavioural reference model.
    int q[$];
    int mbits[$];
    bit m_act = 0, m_st;
    int m_cnt = 0, m_tpb = 0, m_pre, m_d, m_f, m_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); mbits.delete(); m_act = 0; m_cnt = 0;
        end else begin
            m_pre = q.size();
            m_st  = !m_act && tx_en && m_pre > 0 && !flush && fmt_code <= 4'd4;
            if (m_act && baud_tick) begin
                if (m_cnt == m_tpb - 1) begin
                    m_cnt = 0;
                    void'(mbits.pop_front());
                    if (mbits.size() == 0) m_act = 0;
                end else m_cnt++;
            end else if (m_st) begin
                m_d = q[0] & 255; m_f = (q[0] >> 8) & 1;
                mbits.delete(); mbits.push_back(0);
                m_n = (fmt_code == 4'd1) ? 7 : 8;
                for (int i = 0; i < m_n; i++) mbits.push_back((m_d >> i) & 1);
                if (fmt_code == 4'd2) mbits.push_back(($countones(m_d) % 2 == 0) ? 1 : 0);
                if (fmt_code == 4'd3) mbits.push_back($countones(m_d) % 2);
                if (fmt_code == 4'd4) mbits.push_back(m_f);
                mbits.push_back(1);
                m_tpb = fast_sel ? 4 : 16; m_cnt = 0; m_act = 1;
            end
            if (flush) q.delete();
            else begin
                if (m_st) void'(q.pop_front());
                if (in_valid && m_pre < DEPTH) q.push_back({23'd0, in_addr, in_data});
            end
        end
    end

    task automatic check(input string name, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check("txd",      txd,      m_act ? logic'(mbits[0] & 1) : 1'b1);
            check("busy",     busy,     m_act);
            check("drive_en", drive_en, m_act && tx_en);
            check("in_ready", in_ready, q.size() < DEPTH);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic push(input logic [7:0] d, input logic a);
        step(1); in_valid = 1'b1; in_data = d; in_addr = a;
        step(1); in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while ((m_act || (q.size() > 0 && tx_en && fmt_code <= 4'd4)) && k < 5000) begin
            step(1); k++;
        end
        step(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset values
        step(3);
        @(negedge clk);
        check("txd", txd, 1'b1); check("busy", busy, 1'b0);
        check("drive_en", drive_en, 1'b0); check("in_ready", in_ready, 1'b1);
        step(1); rst_n = 1'b1; step(3);

        cur_req = "R2"; tx_en = 1'b1; fast_sel = 1'b1; fmt_code = 4'b0000;
        push(8'hA5, 1'b0); push(8'h3C, 1'b0); wait_idle();
        cur_req = "R3"; fmt_code = 4'b0001;
        push(8'hFE, 1'b0); push(8'h55, 1'b0); wait_idle();
        cur_req = "R4"; fmt_code = 4'b0010;
        push(8'h01, 1'b0); push(8'h03, 1'b0); wait_idle();
        cur_req = "R5"; fmt_code = 4'b0011;
        push(8'h01, 1'b0); push(8'h03, 1'b0); wait_idle();
        cur_req = "R6"; fmt_code = 4'b0100;
        push(8'h12, 1'b1); push(8'h34, 1'b0); wait_idle();

        cur_req = "R7"; fast_sel = 1'b0; tick_div = 3; fmt_code = 4'b0000;
        push(8'h6B, 1'b0); wait_idle();
        tick_div = 1;

        cur_req = "R12"; fast_sel = 1'b1; fmt_code = 4'b0010;
        push(8'h5A, 1'b0); step(8); fmt_code = 4'b0001; fast_sel = 1'b0;
        wait_idle(); fmt_code = 4'b0000; fast_sel = 1'b1;

        cur_req = "R8"; push(8'hC3, 1'b0); step(6); tx_en = 1'b0;
        cur_req = "R9"; push(8'h11, 1'b0); push(8'h22, 1'b0);
        wait_idle(); step(30); tx_en = 1'b1; wait_idle();

        cur_req = "R13"; tx_en = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h40 + i), 1'b0);
        @(negedge clk); check("in_ready full", in_ready, 1'b0);

        cur_req = "R10"; step(1); flush = 1'b1; in_valid = 1'b1; in_data = 8'h99;
        step(1); flush = 1'b0; in_valid = 1'b0; tx_en = 1'b1; step(40);
        @(negedge clk); check("busy after flush", busy, 1'b0);
        push(8'h81, 1'b0); wait_idle();

        cur_req = "R11"; fmt_code = 4'b0101; push(8'h77, 1'b0); step(40);
        @(negedge clk); check("busy code 0101", busy, 1'b0);
        fmt_code = 4'b1101; step(20);
        @(negedge clk); check("busy code 1101", busy, 1'b0);
        fmt_code = 4'b1111; step(20);
        @(negedge clk); check("txd code 1111", txd, 1'b1);
        fmt_code = 4'b0000; wait_idle();

        finish_run();
    end
endmodule